// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Engine

This block carries out one atomic memory operation at a time on a local synchronous RAM, on behalf of requests that arrive from a packet interface. Each request names an operation, a byte address and an operand size. A test-and-swap request also carries an 8-byte payload. The engine reads the addressed word and keeps the selected bytes. It works out the replacement value and writes the changed bytes back under byte enables. It then returns the prior contents in a 64-bit response with a status code.

The engine accepts nothing new from the moment it takes a request until its response has gone out. No other access can reach the memory between the read and the write-back. Requests with an illegal size, a misaligned address or an unknown operation code are answered with an error status and do not touch the memory. Memory words are little-endian: byte k of a word sits at bits 8k+7:8k, and the low two address bits select the starting byte lane.

Top module: `atomic_rmw_engine`

## Requirements
- R1: Operation code 0 increments the operand and code 1 decrements it. Both wrap modulo 2^(8*size), and only the selected bytes are rewritten.
- R2: Operation code 2 is test-and-swap. Its operand is taken from payload bytes (addr mod 8) to (addr mod 8)+size-1, with payload byte k at bits 8k+7:8k. That operand is written only when the current operand bytes are all zero. Otherwise no write cycle is issued.
- R3: Operation code 3 writes all-ones and code 4 writes all-zeros into the selected bytes. The other bytes of the word keep their value, and write byte enables cover only the selected lanes.
- R4: Legal sizes are 1, 2 and 4 bytes, with the address a multiple of the size. Any other size (0, 3, 5 to 15) or a misaligned address gets status 2'b01 and causes no memory access.
- R5: Operation codes 5, 6 and 7 get status 2'b01 and cause no memory access.
- R6: A completed request returns status 2'b00 and, in rsp_data, the prior operand right-justified and zero-extended to 64 bits. An error response carries all-zero data.
- R7: A legal request makes exactly one read of the addressed word. If it writes, it makes exactly one write to the same word two cycles later, with no memory access in the cycle between.
- R8: req_ready is low from the cycle after an accepted request through the response cycle, and high again in the cycle after the response. A request held valid during that time is accepted only once.
- R9: rsp_valid pulses for one cycle. It comes 1 cycle after acceptance for an error, 3 cycles after for a legal request with no write, and 4 cycles after for a legal request that writes back.
- R10: While rst_n is low, req_ready, rsp_valid and mem_en are low. The reset is released through a two-stage synchronizer, so req_ready rises on the second clock edge after rst_n rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle and able to accept |
| req_op | input | 3 | Operation code |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 4 | Operand size in bytes |
| req_swap | input | 64 | Test-and-swap payload |
| rsp_valid | output | 1 | Response strobe |
| rsp_status | output | 2 | 2'b00 done, 2'b01 error |
| rsp_data | output | 64 | Prior operand value, right-justified |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write |
| mem_addr | output | ADDR_W-2 | Memory word address |
| mem_be | output | DATA_W/8 | Write byte enables |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, one cycle after the read |

## Verification
The bench sweeps every operation code, every size from 0 to 8 plus 15, and every byte offset. It runs each combination against memory words holding all-zeros, all-ones and mixed patterns. This covers increment and decrement wrap at each width, including a carry that must not leak into neighbouring bytes, which a design with a wrong mask would corrupt. It also covers test-and-swap against zero and non-zero lanes: a design that tested the whole word, or always wrote, would change memory it should leave alone. Misaligned and odd sizes, together with unknown codes, are checked for silent memory and zero data. The bench counts every memory access per request to catch a stray extra read or an early write, and it holds a request valid across a whole operation to catch double acceptance.

// File: rtl/atomic_rmw_pkg.sv
package atomic_rmw_pkg;
  localparam int SIZE_W = 4;
  localparam int RSP_W  = 64;
  localparam int PAY_OFF_W = 3;

  localparam logic [2:0] OP_INC   = 3'd0;
  localparam logic [2:0] OP_DEC   = 3'd1;
  localparam logic [2:0] OP_TSWAP = 3'd2;
  localparam logic [2:0] OP_SET   = 3'd3;
  localparam logic [2:0] OP_CLR   = 3'd4;

  localparam logic [1:0] ST_DONE = 2'b00;
  localparam logic [1:0] ST_ERR  = 2'b01;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_RD   = 3'd1,
    S_CAP  = 3'd2,
    S_WR   = 3'd3,
    S_RSP  = 3'd4
  } eng_state_t;
endpackage

// File: rtl/atomic_req_check.sv
module atomic_req_check
  import atomic_rmw_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  localparam int BYTES = DATA_W / 8,
  localparam int OFF_W = $clog2(BYTES),
  localparam int WA_W  = ADDR_W - OFF_W
) (
  input  logic [2:0]        op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [SIZE_W-1:0] size,
  output logic              legal,
  output logic [WA_W-1:0]   word_addr,
  output logic [OFF_W-1:0]  lane,
  output logic [BYTES-1:0]  be
);
  logic size_ok;
  logic op_ok;

  always_comb begin
    lane      = addr[OFF_W-1:0];
    word_addr = addr[ADDR_W-1:OFF_W];
    size_ok   = 1'b0;
    for (int i = 0; i <= OFF_W; i++) begin
      if (int'(size) == (1 << i) && (int'(lane) % (1 << i)) == 0) size_ok = 1'b1;
    end
    op_ok = (op <= OP_CLR);
    legal = size_ok && op_ok;
    for (int b = 0; b < BYTES; b++) begin
      be[b] = (b >= int'(lane)) && (b < int'(lane) + int'(size));
    end
  end
endmodule

// File: rtl/atomic_alu.sv
module atomic_alu
  import atomic_rmw_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int BYTES = DATA_W / 8
) (
  input  logic [2:0]        op,
  input  logic [SIZE_W-1:0] size,
  input  logic [DATA_W-1:0] raw,
  input  logic [DATA_W-1:0] swap,
  output logic [DATA_W-1:0] old_val,
  output logic [DATA_W-1:0] new_val,
  output logic              do_write
);
  logic [DATA_W-1:0] mask;

  always_comb begin
    for (int b = 0; b < BYTES; b++) begin
      mask[8*b +: 8] = (b < int'(size)) ? 8'hFF : 8'h00;
    end
    old_val  = raw & mask;
    do_write = 1'b1;
    unique case (op)
      OP_INC:   new_val = (old_val + DATA_W'(1)) & mask;
      OP_DEC:   new_val = (old_val - DATA_W'(1)) & mask;
      OP_TSWAP: begin
        do_write = (old_val == '0);
        new_val  = do_write ? (swap & mask) : old_val;
      end
      OP_SET:   new_val = mask;
      OP_CLR:   new_val = '0;
      default:  new_val = old_val;
    endcase
  end
endmodule

// File: rtl/atomic_rmw_engine.sv
module atomic_rmw_engine
  import atomic_rmw_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  localparam int BYTES = DATA_W / 8,
  localparam int OFF_W = $clog2(BYTES),
  localparam int WA_W  = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_size,
  input  logic [63:0]       req_swap,
  output logic              rsp_valid,
  output logic [1:0]        rsp_status,
  output logic [63:0]       rsp_data,
  output logic              mem_en,
  output logic              mem_we,
  output logic [WA_W-1:0]   mem_addr,
  output logic [BYTES-1:0]  mem_be,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  // reset release synchronizer
  logic [1:0] rs_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  eng_state_t state_q, state_d;

  logic              accept;
  logic              legal;
  logic [WA_W-1:0]   word_c;
  logic [OFF_W-1:0]  lane_c;
  logic [BYTES-1:0]  be_c;
  logic [DATA_W-1:0] swap_c;

  logic [2:0]        op_q;
  logic [SIZE_W-1:0] size_q;
  logic [DATA_W-1:0] swap_q;
  logic [WA_W-1:0]   word_q;
  logic [OFF_W-1:0]  off_q;
  logic [BYTES-1:0]  be_q;
  logic              err_q;
  logic [DATA_W-1:0] old_q;
  logic [DATA_W-1:0] new_q;

  logic [DATA_W-1:0] raw_c;
  logic [DATA_W-1:0] old_c;
  logic [DATA_W-1:0] new_c;
  logic              wr_c;
  logic              ld_req;
  logic              ld_cap;

  atomic_req_check #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_check (
    .op        (req_op),
    .addr      (req_addr),
    .size      (req_size),
    .legal     (legal),
    .word_addr (word_c),
    .lane      (lane_c),
    .be        (be_c)
  );

  // payload operand starts at the address's byte position within the double-word
  assign swap_c = DATA_W'(req_swap >> {req_addr[PAY_OFF_W-1:0], 3'b000});
  assign raw_c  = DATA_W'(mem_rdata >> {off_q, 3'b000});

  atomic_alu #(.DATA_W(DATA_W)) u_alu (
    .op       (op_q),
    .size     (size_q),
    .raw      (raw_c),
    .swap     (swap_q),
    .old_val  (old_c),
    .new_val  (new_c),
    .do_write (wr_c)
  );

  assign req_ready = (state_q == S_IDLE) && rst_i_n;
  assign accept    = req_valid && req_ready;
  assign ld_req    = accept;
  assign ld_cap    = (state_q == S_CAP);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:  if (accept) state_d = legal ? S_RD : S_RSP;
      S_RD:    state_d = S_CAP;
      S_CAP:   state_d = wr_c ? S_WR : S_RSP;
      S_WR:    state_d = S_RSP;
      S_RSP:   state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) state_q <= S_IDLE;
    else          state_q <= state_d;
  end

  always_ff @(posedge clk) begin
    if (ld_req) begin
      op_q   <= req_op;
      size_q <= req_size;
      swap_q <= swap_c;
      word_q <= word_c;
      off_q  <= lane_c;
      be_q   <= be_c;
      err_q  <= !legal;
    end
  end

  always_ff @(posedge clk) begin
    if (ld_cap) begin
      old_q <= old_c;
      new_q <= new_c << {off_q, 3'b000};
    end
  end

  assign mem_en     = (state_q == S_RD) || (state_q == S_WR);
  assign mem_we     = (state_q == S_WR);
  assign mem_addr   = word_q;
  assign mem_be     = be_q;
  assign mem_wdata  = new_q;
  assign rsp_valid  = (state_q == S_RSP);
  assign rsp_status = err_q ? ST_ERR : ST_DONE;
  assign rsp_data   = err_q ? '0 : {{(RSP_W-DATA_W){1'b0}}, old_q};

  // R8: no back-to-back acceptance while an operation is open
  p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_i_n)
    (req_valid && req_ready) |=> !req_ready);

  // R8: engine reopens right after the response
  p_ready_after_rsp_r8: assert property (@(posedge clk) disable iff (!rst_i_n)
    rsp_valid |=> req_ready);

  // R7: a write is preceded by a read of the same word two cycles earlier, nothing between
  p_write_follows_read_r7: assert property (@(posedge clk) disable iff (!rst_i_n)
    mem_we |-> ($past(mem_en, 2) && !$past(mem_we, 2) && !$past(mem_en, 1)
                && ($past(mem_addr, 2) == mem_addr)));

  // R4 / R5: illegal request answered next cycle with error and no memory traffic
  p_illegal_quiet_r4: assert property (@(posedge clk) disable iff (!rst_i_n)
    (req_valid && req_ready && !legal) |=> (rsp_valid && rsp_status == ST_ERR && !mem_en));

  // R3: write enables cover a legal operand width only
  p_write_be_width_r3: assert property (@(posedge clk) disable iff (!rst_i_n)
    mem_we |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2 || $countones(mem_be) == 4));

  // R9: response strobe lasts one cycle
  p_rsp_single_r9: assert property (@(posedge clk) disable iff (!rst_i_n)
    rsp_valid |=> !rsp_valid);
endmodule

// File: tb/atomic_rmw_engine_tb.sv
module atomic_rmw_engine_tb;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 32;
  localparam int WORDS  = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [2:0]  req_op;
  logic [5:0]  req_addr;
  logic [3:0]  req_size;
  logic [63:0] req_swap;
  logic        rsp_valid;
  logic [1:0]  rsp_status;
  logic [63:0] rsp_data;
  logic        mem_en;
  logic        mem_we;
  logic [3:0]  mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata;

  logic [31:0] mem_arr [WORDS];

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int rd_n, wr_n, exp_word;
  bit ord_bad, addr_bad;

  always #2.5 clk = ~clk;

  atomic_rmw_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_size(req_size), .req_swap(req_swap),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_data(rsp_data),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // synchronous RAM model, read-before-write
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem_arr[mem_addr][8*b +: 8] <= mem_wdata[8*b +: 8];
      end
      mem_rdata <= mem_arr[mem_addr];
    end
  end

  // access monitor
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin
        if (rd_n == 0) ord_bad = 1'b1;
        wr_n++;
      end else begin
        if (wr_n != 0) ord_bad = 1'b1;
        rd_n++;
      end
      if (int'(mem_addr) != exp_word) addr_bad = 1'b1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic run_op(input logic [2:0] op, input int sz, input int off, input int word,
                        input logic [31:0] init, input logic [63:0] pay, input bit hold);
    int lane8, lat, k, exp_rd, exp_wr;
    bit legal, wr, got, busy_bad;
    logic [31:0] old, sw, nw, mask, exp_w;
    string mtag, stag;
    lane8 = (word * 4 + off) % 8;
    legal = (op <= 3'd4) && (sz == 1 || sz == 2 || sz == 4);
    if (legal) legal = ((off % sz) == 0);
    old = '0; sw = '0; mask = '0; nw = '0; wr = 1'b0;
    if (legal) begin
      for (int b = 0; b < 4; b++) begin
        if (b < sz) begin
          mask[8*b +: 8] = 8'hFF;
          old[8*b +: 8]  = init[8*(off+b) +: 8];
          sw[8*b +: 8]   = pay[8*(lane8+b) +: 8];
        end
      end
      wr = 1'b1;
      case (op)
        3'd0: nw = (old + 32'd1) & mask;
        3'd1: nw = (old - 32'd1) & mask;
        3'd2: begin wr = (old == 32'd0); nw = wr ? sw : old; end
        3'd3: nw = mask;
        default: nw = 32'd0;
      endcase
    end
    exp_w = init;
    if (legal && wr)
      for (int b = 0; b < 4; b++)
        if (b < sz) exp_w[8*(off+b) +: 8] = nw[8*b +: 8];
    lat    = !legal ? 1 : (wr ? 4 : 3);
    exp_rd = legal ? 1 : 0;
    exp_wr = (legal && wr) ? 1 : 0;
    if (op > 3'd4)       mtag = "R5";
    else if (!legal)     mtag = "R4";
    else if (op <= 3'd1) mtag = "R1";
    else if (op == 3'd2) mtag = "R2";
    else                 mtag = "R3";
    stag = legal ? "R6" : mtag;

    mem_arr[word] = init;
    rd_n = 0; wr_n = 0; ord_bad = 1'b0; addr_bad = 1'b0; exp_word = word;
    req_op = op; req_size = 4'(sz); req_addr = 6'(word * 4 + off); req_swap = pay;
    req_valid = 1'b1;
    k = 0; got = 1'b0; busy_bad = 1'b0;
    while (!got && k < 10) begin
      @(negedge clk);
      k++;
      if (!hold) req_valid = 1'b0;
      if (req_ready) busy_bad = 1'b1;
      if (rsp_valid) got = 1'b1;
    end
    chk(k == lat, "R9 latency", 64'(k), 64'(lat));
    chk(rsp_status == (legal ? 2'b00 : 2'b01), stag, 64'(rsp_status), legal ? 64'd0 : 64'd1);
    chk(rsp_data == 64'(old), "R6 data", rsp_data, 64'(old));
    chk(!busy_bad, "R8 ready low while busy", 64'(busy_bad), 64'd0);
    req_valid = 1'b0;
    @(negedge clk);
    chk(req_ready && !rsp_valid, "R8 ready back", {62'd0, req_ready, rsp_valid}, 64'd2);
    chk(mem_arr[word] == exp_w, mtag, 64'(mem_arr[word]), 64'(exp_w));
    chk(rd_n == exp_rd && wr_n == exp_wr && !ord_bad && !addr_bad, legal ? "R7" : mtag,
        64'(rd_n * 16 + wr_n), 64'(exp_rd * 16 + exp_wr));
  endtask

  initial begin
    logic [31:0] pats [5];
    int wd;
    pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF; pats[2] = 32'h0000_FFFF;
    pats[3] = 32'h80FF_0001; pats[4] = 32'h7F00_00FE;
    for (int w = 0; w < WORDS; w++) mem_arr[w] = 32'h0;
    rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_addr = '0; req_size = '0; req_swap = '0;
    exp_word = 0; rd_n = 0; wr_n = 0;
    repeat (3) @(negedge clk);
    chk(!req_ready && !rsp_valid && !mem_en, "R10 reset quiet",
        {61'd0, req_ready, rsp_valid, mem_en}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!req_ready, "R10 sync stage 1", 64'(req_ready), 64'd0);
    @(negedge clk);
    chk(req_ready, "R10 ready after release", 64'(req_ready), 64'd1);

    for (int p = 0; p < 5; p++)
      for (int op = 0; op < 8; op++)
        for (int s = 0; s < 10; s++)
          for (int off = 0; off < 4; off++) begin
            wd = (op * 3 + s + p * 5 + off) % WORDS;
            run_op(3'(op), (s == 9) ? 15 : s, off, wd, pats[p],
                   {32'hCAFE_F00D, 32'h9E37_79B9 + 32'(op * 37 + off * 11 + s * 3 + p)}, 1'b0);
          end

    // held-valid requests: accepted once only
    run_op(3'd0, 4, 0, 3, 32'h1234_5678, 64'h0, 1'b1);
    run_op(3'd2, 2, 2, 5, 32'h0000_ABCD, 64'h1111_2222_3333_4444, 1'b1);
    run_op(3'd6, 1, 1, 7, 32'h5555_AAAA, 64'h0, 1'b1);
    // swap into upper payload half, odd word
    run_op(3'd2, 1, 3, 9, 32'h00FF_FFFF, 64'h7700_0000_0000_0000, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule